// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit logical address into a physical address. It does this by walking a two-level page table that sits in memory and uses 4 KiB pages. The CPU side hands over one address at a time through a valid/ready handshake.

The walker forms the address of the first-level descriptor from a root-table base input and reads it. It then reads the second-level descriptor that the first one points to. Each read uses a port that has only one request in flight at a time. The result is a one-cycle response carrying either a physical address with its permission bits, or a fault that names the level whose descriptor was not valid.

The logical address splits into three fields. Bits 31:22 index the first-level table, bits 21:12 index the second-level table, and bits 11:0 are the byte offset within the page. Every descriptor is a 4-byte word with this layout:

- bit 0 is the valid flag.
- bits 3:1 carry the permission triple.
- bits 31:12 hold a 4 KiB-aligned page number. In a first-level descriptor this is the second-level table. In a second-level descriptor it is the data frame.
- bits 11:4 are ignored.

Top module: `pt_walk2`

## Requirements
- R1: After reset the walker is idle: req_ready is 1, and rsp_valid and mem_rd_valid are 0.
- R2: The first read of a walk goes to root_base + 4 × req_vaddr[31:22]. root_base is sampled in the cycle the request is accepted, and later changes to it do not affect that walk.
- R3: The second read goes to {first_descriptor[31:12], req_vaddr[21:12], 2'b00}.
- R4: mem_rd_valid stays high with a stable mem_rd_addr until mem_rd_ready is seen. Exactly one read is outstanding at a time, and a walk issues no read other than these.
- R5: When both descriptors have bit 0 set, the response has rsp_fault = 0. In that case rsp_paddr = {second_descriptor[31:12], req_vaddr[11:0]} and rsp_perm = second_descriptor[3:1]. Descriptor bits 11:4 have no effect.
- R6: A first-level descriptor with bit 0 clear ends the walk with rsp_fault = 1 and rsp_fault_lvl = 0. No second read is made.
- R7: A second-level descriptor with bit 0 clear ends the walk with rsp_fault = 1 and rsp_fault_lvl = 1.
- R8: rsp_valid is high for exactly one cycle, and req_ready is 1 again in the next cycle. req_ready stays 0 from acceptance until the response.
- R9: A fault response drives rsp_paddr and rsp_perm to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| root_base | input | 32 | Byte address of the first-level table |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to accept |
| req_vaddr | input | 32 | Logical address to translate |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_fault | output | 1 | Translation failed |
| rsp_fault_lvl | output | 1 | Failing level: 0 first, 1 second |
| rsp_paddr | output | 32 | Translated physical address |
| rsp_perm | output | 3 | Permission bits of the page |
| mem_rd_valid | output | 1 | Descriptor read request |
| mem_rd_ready | input | 1 | Memory accepts the read |
| mem_rd_addr | output | 32 | Descriptor byte address |
| mem_rsp_valid | input | 1 | Read data strobe |
| mem_rsp_data | input | 32 | Descriptor word |

## Verification
A wrong internal state shows up at the memory port first. If the latched address or table base is corrupted, mem_rd_addr carries a wrong value on the very first or second read request. That request appears a cycle after acceptance, or a cycle after the first descriptor returns.

A state that skips or repeats a level changes the number of reads logged per walk. A wrong state also shows as a response that comes early, comes late, or lasts more than one cycle, or as a wrong fault level. Each of these is seen no later than the response cycle of the walk that went wrong.

// File: rtl/pt_walk2.sv
module pt_walk2 (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] root_base,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_vaddr,
  output logic        rsp_valid,
  output logic        rsp_fault,
  output logic        rsp_fault_lvl,
  output logic [31:0] rsp_paddr,
  output logic [2:0]  rsp_perm,
  output logic        mem_rd_valid,
  input  logic        mem_rd_ready,
  output logic [31:0] mem_rd_addr,
  input  logic        mem_rsp_valid,
  input  logic [31:0] mem_rsp_data
);

  localparam int OFS_W = 12;
  localparam int IDX_W = 10;
  localparam int PN_W  = 32 - OFS_W;

  typedef enum logic [2:0] {IDLE, READ_OUTER, READ_INNER, DONE, FAULT} st_t;

  st_t              st;
  logic [31:0]      va;
  logic [31:0]      root;
  logic [PN_W-1:0]  tbl;
  logic [PN_W-1:0]  frame;
  logic [2:0]       perm;
  logic             lvl;
  logic             issued;
  logic             desc_ok;
  logic             unused_bits;

  assign desc_ok     = mem_rsp_data[0];
  assign unused_bits = ^mem_rsp_data[OFS_W-1:4];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= IDLE;
      va     <= '0;
      root   <= '0;
      tbl    <= '0;
      frame  <= '0;
      perm   <= '0;
      lvl    <= 1'b0;
      issued <= 1'b0;
    end else begin
      case (st)
        IDLE: if (req_valid) begin
          va     <= req_vaddr;
          root   <= root_base;
          issued <= 1'b0;
          st     <= READ_OUTER;
        end
        READ_OUTER: begin
          if (mem_rd_valid && mem_rd_ready) issued <= 1'b1;
          if (issued && mem_rsp_valid) begin
            if (!desc_ok) begin
              lvl <= 1'b0;
              st  <= FAULT;
            end else begin
              tbl    <= mem_rsp_data[31:OFS_W];
              issued <= 1'b0;
              st     <= READ_INNER;
            end
          end
        end
        READ_INNER: begin
          if (mem_rd_valid && mem_rd_ready) issued <= 1'b1;
          if (issued && mem_rsp_valid) begin
            if (!desc_ok) begin
              lvl <= 1'b1;
              st  <= FAULT;
            end else begin
              frame <= mem_rsp_data[31:OFS_W];
              perm  <= mem_rsp_data[3:1];
              st    <= DONE;
            end
          end
        end
        default: st <= IDLE;
      endcase
    end
  end

  assign req_ready    = (st == IDLE);
  assign mem_rd_valid = (st == READ_OUTER || st == READ_INNER) && !issued;
  assign mem_rd_addr  = (st == READ_INNER)
                      ? {tbl, va[OFS_W+IDX_W-1:OFS_W], 2'b00}
                      : root + {20'd0, va[31:OFS_W+IDX_W], 2'b00};

  assign rsp_valid     = (st == DONE) || (st == FAULT);
  assign rsp_fault     = (st == FAULT);
  assign rsp_fault_lvl = (st == FAULT) && lvl;
  assign rsp_paddr     = (st == DONE) ? {frame, va[OFS_W-1:0]} : '0;
  assign rsp_perm      = (st == DONE) ? perm : '0;

endmodule

// File: rtl/pt_walk2_chk.sv
module pt_walk2_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_ready,
  input logic        rsp_valid,
  input logic        rsp_fault,
  input logic        rsp_fault_lvl,
  input logic [31:0] rsp_paddr,
  input logic [2:0]  rsp_perm,
  input logic        mem_rd_valid,
  input logic        mem_rd_ready,
  input logic [31:0] mem_rd_addr
);

  // R4
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid && !mem_rd_ready |=> mem_rd_valid && $stable(mem_rd_addr));

  // R4
  rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ready && mem_rd_valid));

  // R8
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid && req_ready);

  // R8
  rsp_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_valid && (req_ready || mem_rd_valid)));

  // R9
  fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> rsp_valid && rsp_paddr == 32'd0 && rsp_perm == 3'd0);

  // R7
  lvl_only_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault_lvl |-> rsp_fault);

endmodule

bind pt_walk2 pt_walk2_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .rsp_fault(rsp_fault), .rsp_fault_lvl(rsp_fault_lvl), .rsp_paddr(rsp_paddr),
  .rsp_perm(rsp_perm), .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready),
  .mem_rd_addr(mem_rd_addr)
);

// File: tb/pt_walk2_test.sv
`timescale 1ns/1ps
module pt_walk2_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] root_base = '0;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        req_ready, rsp_valid, rsp_fault, rsp_fault_lvl;
  logic [31:0] rsp_paddr;
  logic [2:0]  rsp_perm;
  logic        mem_rd_valid, mem_rd_ready, mem_rsp_valid;
  logic [31:0] mem_rd_addr, mem_rsp_data;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  logic [31:0] root_ref = 32'h0010_0000;

  always #2 clk = ~clk;

  pt_walk2 uut (
    .clk(clk), .rst_n(rst_n), .root_base(root_base),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_fault_lvl(rsp_fault_lvl),
    .rsp_paddr(rsp_paddr), .rsp_perm(rsp_perm),
    .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  function automatic logic [31:0] outer_ent(input int i);
    logic ok = (i % 5) != 3;
    return {20'(32'h200 + i), 8'(i * 3), 3'(i), ok};
  endfunction

  function automatic logic [31:0] inner_ent(input int i, input int j);
    logic ok = ((i + j) % 7) != 2;
    return {20'(i * 31 + j * 17 + 5), 8'(j), 3'(i + j), ok};
  endfunction

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    logic [31:0] off = a - root_ref;
    if (off < 32'd4096) return outer_ent(int'(off[11:2]));
    if (a[31:12] >= 20'h00200 && a[31:12] < 20'h00600)
      return inner_ent(int'(a[31:12] - 20'h00200), int'(a[11:2]));
    return 32'd0;
  endfunction

  logic [4:0]  lfsr;
  logic        pend;
  logic [1:0]  lat;
  logic [31:0] pend_addr;
  logic [7:0]  rd_n;
  logic [31:0] rd_log [256];

  assign mem_rd_ready  = lfsr[0] | lfsr[3];
  assign mem_rsp_valid = pend && lat == 2'd0;
  assign mem_rsp_data  = mem_rsp_valid ? mem_word(pend_addr) : 32'hDEAD_BEEF;

  always @(posedge clk) begin
    if (!rst_n) begin
      lfsr <= 5'h13;
      pend <= 1'b0;
      lat  <= '0;
      pend_addr <= '0;
      rd_n <= '0;
    end else begin
      lfsr <= {lfsr[3:0], lfsr[4] ^ lfsr[2]};
      if (mem_rd_valid && mem_rd_ready && !pend) begin
        pend <= 1'b1;
        pend_addr <= mem_rd_addr;
        lat <= lfsr[2:1];
        rd_log[rd_n] <= mem_rd_addr;
        rd_n <= rd_n + 8'd1;
      end else if (pend) begin
        if (lat == 2'd0) pend <= 1'b0;
        else lat <= lat - 2'd1;
      end
    end
  end

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic walk(input logic [31:0] va, input logic [31:0] base);
    int i = int'(va[31:22]);
    int j = int'(va[21:12]);
    logic [31:0] o = outer_ent(i);
    logic [31:0] n = inner_ent(i, j);
    logic [31:0] a1 = base + {20'd0, va[31:22], 2'b00};
    logic [31:0] a2 = {o[31:12], va[21:12], 2'b00};
    logic [7:0] start;
    int wait_n = 0;
    logic busy_bad = 1'b0;
    @(negedge clk);
    chk(req_ready, "R8 ready before request", 32'(req_ready), 32'd1);
    root_base = base;
    root_ref  = base;
    req_vaddr = va;
    req_valid = 1'b1;
    start = rd_n;
    @(negedge clk);
    req_valid = 1'b0;
    root_base = ~base;
    req_vaddr = ~va;
    while (!rsp_valid && wait_n < 200) begin
      if (req_ready) busy_bad = 1'b1;
      @(negedge clk);
      wait_n++;
    end
    chk(rsp_valid, "R8 response arrives", 32'(rsp_valid), 32'd1);
    chk(!busy_bad, "R8 ready low while walking", 32'(busy_bad), 32'd0);
    chk(rd_log[start] == a1, "R2 first read address", rd_log[start], a1);
    if (!o[0]) begin
      chk(rsp_fault && !rsp_fault_lvl, "R6 fault at first level",
          {30'd0, rsp_fault, rsp_fault_lvl}, 32'd2);
      chk(8'(rd_n - start) == 8'd1, "R6 single read", 32'(8'(rd_n - start)), 32'd1);
      chk(rsp_paddr == 0 && rsp_perm == 0, "R9 fault zeros", rsp_paddr | 32'(rsp_perm), 32'd0);
    end else begin
      chk(8'(rd_n - start) == 8'd2, "R4 two reads", 32'(8'(rd_n - start)), 32'd2);
      chk(rd_log[8'(start + 8'd1)] == a2, "R3 second read address", rd_log[8'(start + 8'd1)], a2);
      if (!n[0]) begin
        chk(rsp_fault && rsp_fault_lvl, "R7 fault at second level",
            {30'd0, rsp_fault, rsp_fault_lvl}, 32'd3);
        chk(rsp_paddr == 0 && rsp_perm == 0, "R9 fault zeros", rsp_paddr | 32'(rsp_perm), 32'd0);
      end else begin
        chk(!rsp_fault, "R5 no fault", 32'(rsp_fault), 32'd0);
        chk(rsp_paddr == {n[31:12], va[11:0]}, "R5 physical address", rsp_paddr, {n[31:12], va[11:0]});
        chk(rsp_perm == n[3:1], "R5 permission bits", 32'(rsp_perm), 32'(n[3:1]));
      end
    end
    @(negedge clk);
    chk(!rsp_valid && req_ready, "R8 one-cycle response", {30'd0, rsp_valid, req_ready}, 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !rsp_valid && !mem_rd_valid, "R1 reset state",
        {29'd0, req_ready, rsp_valid, mem_rd_valid}, 32'd4);
    for (int i = 0; i < 1024; i++)
      walk({10'(i), 10'(i * 13 + 1), 12'(i * 37)}, i[0] ? 32'h0080_0000 : 32'h0010_0000);
    for (int j = 0; j < 1024; j++)
      walk({10'd4, 10'(j), 12'hABC}, 32'h0010_0000);
    walk({10'd3, 10'd0, 12'h000}, 32'h0080_0000);
    walk({10'd1023, 10'd1023, 12'hFFF}, 32'h0010_0000);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    while (cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule